// File: doc/BRIEF.md
# Sync-Hunt Serial Receiver

This block takes in a byte-synchronous serial bit stream, one bit per cycle in which the receive clock enable is high. It starts in a hunt phase. In that phase it slides a window over the incoming bits and looks for a programmed sync pattern of one or two bytes. In external mode it waits for a sync strobe instead. Once it has locked, it cuts the stream into characters of a configured length, starting at the bit that follows the sync pattern. It checks an optional parity bit on each character and feeds the data bits into a running CRC. Characters are handed out on a valid/ready stream.

The receiver returns to hunting when re-hunt is requested, when it is disabled, or when reset is asserted. With automatic enabling turned on, it is also disabled whenever the carrier-detect input is low.

The serial side cannot be stalled, so the output holds one pending character. While valid is high and ready is low, the character and its parity flag stay unchanged. If another character completes before the consumer takes the pending one, the newer character replaces it. The consumer must therefore accept each character within one character time.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset `synced` is 0, `out_valid` is 0 and `crc_zero` is 1, because the CRC starts at zero.
- R2: In mode 00, the receiver locks on the enable cycle whose bit completes a match. A match means the last 8 bits received, taken LSB first, equal `sync_hi`. No lock happens before 8 bits have arrived since the hunt began. The next bit is bit 0 of the first character.
- R3: In mode 01, locking needs `sync_lo` followed by `sync_hi` within a 16-bit window, each byte LSB first. A single matching byte, or the two bytes in the wrong order, does not lock.
- R4: In mode 11, the receiver locks on an enable cycle in which `ext_sync` is high. That cycle's bit is discarded, and the next bit starts the first character.
- R5: The character length code maps as follows: 00 gives 5 bits, 10 gives 6, 01 gives 7 and 11 gives 8. Data is received LSB first, right-justified in `out_data`, and unused upper bits are 0.
- R6: With `cfg_par_en` set, one parity bit follows the data bits. `cfg_par_even`=1 demands an even count of ones over data plus parity bit, and 0 demands an odd count. `out_par_err` flags a violation together with the character. With `cfg_par_en` clear, the flag is 0.
- R7: With `cfg_sync_inhibit` set, a character equal to the sync byte is not delivered and does not enter the CRC. The sync byte is `sync_hi`, or in mode 01 either sync register, masked to the character length.
- R8: The CRC uses polynomial 0x1021 and is shifted one data bit at a time, in arrival order, with feedback taken from bit 15. It is cleared to zero on lock. It advances only when `cfg_crc_en` is set. `crc_zero` is 1 when the register is zero, so it goes high after the received check bytes.
- R9: A cycle with `cfg_hunt` high clears `synced` at the next edge and discards any partial character.
- R10: When `cfg_rx_en` is 0, or when `cfg_auto_en` is 1 and `dcd` is 0, the receiver drops lock at the next edge, stays unlocked and delivers no characters.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_par_err` hold. A character completing in that state replaces the pending one.
- R12: Mode 10 never locks, whatever the bits or the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Receive clock enable: `bit_in` is taken in this cycle |
| bit_in | input | 1 | Serial data |
| ext_sync | input | 1 | External sync strobe (mode 11) |
| dcd | input | 1 | Carrier detect, high when active |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_hunt | input | 1 | Re-hunt request |
| cfg_auto_en | input | 1 | Gate the receiver with `dcd` |
| cfg_sync_inhibit | input | 1 | Suppress characters equal to the sync byte |
| cfg_crc_en | input | 1 | Include characters in the CRC |
| cfg_char_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even, 0 = odd parity |
| cfg_sync_mode | input | 2 | 00 one byte, 01 two bytes, 10 none, 11 external |
| sync_lo | input | 8 | First sync byte (mode 01) |
| sync_hi | input | 8 | Sync byte (mode 00), second byte (mode 01) |
| out_data | output | 8 | Received character |
| out_valid | output | 1 | Character pending |
| out_ready | input | 1 | Consumer accepts the pending character |
| out_par_err | output | 1 | Parity error for the pending character |
| synced | output | 1 | Lock acquired |
| crc_zero | output | 1 | CRC register equals zero |

## Verification
A wrong window or a wrong fill count shows up at the lock bit itself. `synced` rises a bit too early or too late, or it rises on a wrong or reversed pattern. Every later character then comes out shifted, and this is visible on the first delivered character. A wrong bit counter or length decode corrupts the first character after lock. A wrong parity sense flips `out_par_err` on that same character. A CRC fault stays hidden until the check bytes arrive, where `crc_zero` fails to rise. Faults in the lock-drop paths show up one cycle after the re-hunt request or the disable.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W + 2);

  typedef enum logic [1:0] {
    MODE_SYNC8  = 2'b00,
    MODE_SYNC16 = 2'b01,
    MODE_NONE   = 2'b10,
    MODE_EXT    = 2'b11
  } sync_mode_e;

  // length code to number of data bits
  function automatic logic [CNT_W-1:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(5);
      2'b10:   return CNT_W'(6);
      2'b01:   return CNT_W'(7);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/shr_hunt.sv
module shr_hunt
  import shr_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          hunt_req,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          ext_sync,
  input  sync_mode_e    mode,
  input  logic [SW-1:0] sync_a,
  input  logic [SW-1:0] sync_b,
  output logic          locked,
  output logic          lock_evt
);
  localparam int WW = 2 * SW;
  localparam int FW = $clog2(WW + 1);

  logic [WW-1:0] win, win_nx;
  logic [FW-1:0] fill, fill_nx;
  logic          match;

  always_comb begin
    win_nx  = {bit_in, win[WW-1:1]};
    fill_nx = (fill == FW'(WW)) ? fill : fill + FW'(1);
    case (mode)
      MODE_SYNC8:  match = (fill_nx >= FW'(SW)) && (win_nx[WW-1:SW] == sync_b);
      MODE_SYNC16: match = (fill_nx == FW'(WW)) && (win_nx == {sync_b, sync_a});
      MODE_EXT:    match = ext_sync;
      default:     match = 1'b0;
    endcase
    lock_evt = active && !hunt_req && !locked && bit_en && match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      fill   <= '0;
      locked <= 1'b0;
    end else if (!active || hunt_req) begin
      win    <= '0;
      fill   <= '0;
      locked <= 1'b0;
    end else if (!locked && bit_en) begin
      win  <= win_nx;
      fill <= fill_nx;
      if (match) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/shr_assemble.sv
module shr_assemble #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          bit_in,
  input  logic [CW-1:0] nbits,
  input  logic          par_en,
  input  logic          par_even,
  output logic          done,
  output logic [W-1:0]  char_data,
  output logic          par_err
);
  localparam int IW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  data, data_nx;
  logic          last;
  logic          ones;

  always_comb begin
    data_nx = data;
    if (cnt < nbits) data_nx[cnt[IW-1:0]] = bit_in;
    last      = (cnt == nbits + CW'(par_en) - CW'(1));
    done      = step && last;
    char_data = data_nx;
    // on the last step of a parity character bit_in is the parity bit
    ones      = (^data_nx) ^ bit_in;
    par_err   = par_en && (ones ^ !par_even);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
    end else if (clear) begin
      cnt  <= '0;
      data <= '0;
    end else if (step) begin
      if (last) begin
        cnt  <= '0;
        data <= '0;
      end else begin
        cnt  <= cnt + CW'(1);
        data <= data_nx;
      end
    end
  end
endmodule

// File: rtl/shr_crc.sv
module shr_crc #(
  parameter int             W      = 8,
  parameter int             CW     = 4,
  parameter int             CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic [W-1:0]     data,
  input  logic [CW-1:0]    nbits,
  output logic [CRC_W-1:0] crc
);
  function automatic logic [CRC_W-1:0] advance(input logic [CRC_W-1:0] c,
                                               input logic [W-1:0]     d,
                                               input logic [CW-1:0]    n);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = 0; i < W; i++) begin
      if (CW'(i) < n) begin
        fb = r[CRC_W-1] ^ d[i];
        r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= INIT;
    else if (clear)  crc <= INIT;
    else if (upd)    crc <= advance(crc, data, nbits);
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import shr_pkg::*;
#(
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              ext_sync,
  input  logic              dcd,
  input  logic              cfg_rx_en,
  input  logic              cfg_hunt,
  input  logic              cfg_auto_en,
  input  logic              cfg_sync_inhibit,
  input  logic              cfg_crc_en,
  input  logic [1:0]        cfg_char_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_sync_mode,
  input  logic [CHAR_W-1:0] sync_lo,
  input  logic [CHAR_W-1:0] sync_hi,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_par_err,
  output logic              synced,
  output logic              crc_zero
);
  sync_mode_e       mode;
  logic             active, locked, lock_evt, step;
  logic [CNT_W-1:0] nbits;
  logic [CHAR_W-1:0] mask, char_data;
  logic             done, par_err, sync_hit, inhibit, deliver;
  logic [CRC_W-1:0] crc;

  always_comb begin
    mode    = sync_mode_e'(cfg_sync_mode);
    active  = cfg_rx_en && (!cfg_auto_en || dcd);
    nbits   = char_bits(cfg_char_len);
    mask    = ~({CHAR_W{1'b1}} << nbits);
    step    = bit_en && locked && active && !cfg_hunt;
    sync_hit = (char_data == (sync_hi & mask)) ||
               ((mode == MODE_SYNC16) && (char_data == (sync_lo & mask)));
    inhibit = cfg_sync_inhibit && sync_hit;
    deliver = done && !inhibit;
  end

  shr_hunt #(.SW(CHAR_W)) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .hunt_req (cfg_hunt),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .ext_sync (ext_sync),
    .mode     (mode),
    .sync_a   (sync_lo),
    .sync_b   (sync_hi),
    .locked   (locked),
    .lock_evt (lock_evt)
  );

  shr_assemble #(.W(CHAR_W), .CW(CNT_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!locked),
    .step      (step),
    .bit_in    (bit_in),
    .nbits     (nbits),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .done      (done),
    .char_data (char_data),
    .par_err   (par_err)
  );

  shr_crc #(.W(CHAR_W), .CW(CNT_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (lock_evt),
    .upd   (done && cfg_crc_en && !inhibit),
    .data  (char_data),
    .nbits (nbits),
    .crc   (crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_par_err <= 1'b0;
    end else if (deliver) begin
      out_valid   <= 1'b1;
      out_data    <= char_data;
      out_par_err <= par_err;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assign synced   = locked;
  assign crc_zero = (crc == '0);
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       cfg_rx_en,
  input logic       cfg_auto_en,
  input logic       dcd,
  input logic       cfg_hunt,
  input logic [1:0] cfg_sync_mode,
  input logic       synced,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_par_err
);
  assert_drop_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rx_en && (!cfg_auto_en || dcd)) |=> !synced);

  assert_hunt_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hunt |=> !synced);

  assert_hold_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !bit_en |=> out_valid && $stable(out_data) && $stable(out_par_err));

  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(bit_en));

  assert_char_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(bit_en));

  assert_mode10_no_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_mode == 2'b10) && !synced |=> !synced);
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (.*);

// File: tb/sync_hunt_rx_test.sv
module sync_hunt_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, bit_in = 0, ext_sync = 0, dcd = 1;
  logic cfg_rx_en = 1, cfg_hunt = 0, cfg_auto_en = 0, cfg_sync_inhibit = 0, cfg_crc_en = 0;
  logic [1:0] cfg_char_len = 2'b11, cfg_sync_mode = 2'b00;
  logic cfg_par_en = 0, cfg_par_even = 1;
  logic [7:0] sync_lo = 8'h32, sync_hi = 8'h16;
  logic [7:0] out_data;
  logic out_valid, out_ready = 1, out_par_err, synced, crc_zero;

  int n_checks = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  logic [8:0] mon_e;
  logic [15:0] crc_m;
  logic [7:0] ck1, ck2;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt_rx uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11 unexpected char: got %0h expected none", out_data);
      end else begin
        mon_e = exp_q.pop_front();
        check("R5 char data", {24'h0, out_data}, {24'h0, mon_e[7:0]});
        check("R6 parity flag", {31'h0, out_par_err}, {31'h0, mon_e[8]});
      end
    end
  end

  function automatic logic [15:0] crc_adv(input logic [15:0] c, input logic [7:0] d, input int n);
    logic fb;
    for (int i = 0; i < n; i++) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic send_char(input logic [7:0] d, input int n, input logic use_par,
                           input logic par_bit, input logic expect_it, input logic perr);
    logic [7:0] m;
    m = 8'((9'h1 << n) - 9'h1);
    if (expect_it) exp_q.push_back({perr, d & m});
    send_bits({8'h00, d}, n);
    if (use_par) send_bit(par_bit);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); cfg_hunt = 1'b1;
    @(negedge clk); cfg_hunt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 synced after reset", {31'h0, synced}, 0);
    check("R1 valid after reset", {31'h0, out_valid}, 0);
    check("R1 crc_zero after reset", {31'h0, crc_zero}, 1);
    rst_n = 1'b1;

    // R2: one-byte hunt
    send_bits(16'h0007, 3);
    check("R2 no lock on noise", {31'h0, synced}, 0);
    send_char(8'h16, 8, 0, 0, 0, 0);
    check("R2 lock on sync byte", {31'h0, synced}, 1);
    send_char(8'h41, 8, 0, 0, 1, 0);
    send_char(8'hA5, 8, 0, 0, 1, 0);

    // R7: sync inhibit
    cfg_sync_inhibit = 1;
    send_char(8'h16, 8, 0, 0, 0, 0);
    send_char(8'h33, 8, 0, 0, 1, 0);
    cfg_sync_inhibit = 0;
    send_char(8'h16, 8, 0, 0, 1, 0);

    // R5: lengths
    cfg_char_len = 2'b00; send_char(8'hF5, 5, 0, 0, 1, 0);
    cfg_char_len = 2'b10; send_char(8'h2A, 6, 0, 0, 1, 0);
    cfg_char_len = 2'b01; send_char(8'h55, 7, 0, 0, 1, 0);

    // R6: parity
    cfg_par_en = 1; cfg_par_even = 1;
    send_char(8'h41, 7, 1, 0, 1, 0);
    send_char(8'h41, 7, 1, 1, 1, 1);
    cfg_par_even = 0;
    send_char(8'h41, 7, 1, 1, 1, 0);
    send_char(8'h41, 7, 1, 0, 1, 1);
    cfg_par_en = 0; cfg_char_len = 2'b11;

    // R9: re-hunt drops partial char and lock
    send_bits(16'h0005, 3);
    pulse_hunt();
    check("R9 unlocked after hunt", {31'h0, synced}, 0);
    send_char(8'h41, 8, 0, 0, 0, 0);
    send_char(8'h41, 8, 0, 0, 0, 0);
    check("R9 stays unlocked", {31'h0, synced}, 0);

    // R2: fill boundary with all-zero sync byte
    sync_hi = 8'h00;
    pulse_hunt();
    send_bits(16'h0000, 7);
    check("R2 no lock before 8 bits", {31'h0, synced}, 0);
    send_bit(1'b0);
    check("R2 lock on 8th bit", {31'h0, synced}, 1);
    send_char(8'h6C, 8, 0, 0, 1, 0);
    sync_hi = 8'h16;

    // R3: two-byte hunt
    pulse_hunt();
    cfg_sync_mode = 2'b01;
    send_char(8'h16, 8, 0, 0, 0, 0);
    check("R3 one byte not enough", {31'h0, synced}, 0);
    send_char(8'h32, 8, 0, 0, 0, 0);
    check("R3 reversed order no lock", {31'h0, synced}, 0);
    send_char(8'h16, 8, 0, 0, 0, 0);
    check("R3 lock on pair", {31'h0, synced}, 1);

    // R8: CRC
    cfg_crc_en = 1;
    check("R8 crc cleared on lock", {31'h0, crc_zero}, 1);
    send_char(8'h01, 8, 0, 0, 1, 0);
    send_char(8'h02, 8, 0, 0, 1, 0);
    check("R8 crc nonzero on data", {31'h0, crc_zero}, 0);
    crc_m = crc_adv(crc_adv(16'h0000, 8'h01, 8), 8'h02, 8);
    for (int i = 0; i < 8; i++) begin
      ck1[i] = crc_m[15-i];
      ck2[i] = crc_m[7-i];
    end
    send_char(ck1, 8, 0, 0, 1, 0);
    send_char(ck2, 8, 0, 0, 1, 0);
    check("R8 crc zero after check bytes", {31'h0, crc_zero}, 1);
    cfg_crc_en = 0;
    send_char(8'h77, 8, 0, 0, 1, 0);
    check("R8 crc held when disabled", {31'h0, crc_zero}, 1);

    // R4: external strobe
    pulse_hunt();
    cfg_sync_mode = 2'b11;
    send_bits(16'h000F, 4);
    check("R4 no lock without strobe", {31'h0, synced}, 0);
    @(negedge clk); bit_in = 1; bit_en = 1; ext_sync = 1;
    @(negedge clk); bit_en = 0; ext_sync = 0;
    check("R4 lock on strobe", {31'h0, synced}, 1);
    send_char(8'h5C, 8, 0, 0, 1, 0);

    // R12: mode 10 never locks
    pulse_hunt();
    cfg_sync_mode = 2'b10;
    send_char(8'h16, 8, 0, 0, 0, 0);
    @(negedge clk); bit_in = 1; bit_en = 1; ext_sync = 1;
    @(negedge clk); bit_en = 0; ext_sync = 0;
    send_char(8'h41, 8, 0, 0, 0, 0);
    check("R12 mode 10 no lock", {31'h0, synced}, 0);

    // R10: auto enables and disable
    cfg_sync_mode = 2'b00;
    send_char(8'h16, 8, 0, 0, 0, 0);
    check("R10 relock", {31'h0, synced}, 1);
    cfg_auto_en = 1;
    @(negedge clk); dcd = 0;
    @(negedge clk);
    check("R10 drop on dcd low", {31'h0, synced}, 0);
    send_char(8'h16, 8, 0, 0, 0, 0);
    send_char(8'h41, 8, 0, 0, 0, 0);
    check("R10 no lock while dcd low", {31'h0, synced}, 0);
    dcd = 1;
    send_char(8'h16, 8, 0, 0, 0, 0);
    check("R10 lock with dcd high", {31'h0, synced}, 1);
    @(negedge clk); cfg_rx_en = 0;
    @(negedge clk);
    check("R10 drop on disable", {31'h0, synced}, 0);
    cfg_rx_en = 1; cfg_auto_en = 0;

    // R11: back-pressure and overwrite
    send_char(8'h16, 8, 0, 0, 0, 0);
    @(posedge clk); #1 out_ready = 0;
    send_char(8'h3C, 8, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R11 valid held", {31'h0, out_valid}, 1);
    check("R11 data held", {24'h0, out_data}, 32'h3C);
    send_char(8'hC3, 8, 0, 0, 1, 0);
    check("R11 overwrite", {24'h0, out_data}, 32'hC3);
    @(posedge clk); #1 out_ready = 1;
    repeat (3) @(negedge clk);
    check("R11 valid cleared", {31'h0, out_valid}, 0);

    check("R5 all chars seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule